// File: doc/BRIEF.md
# Receive Descriptor Ring Writer with Pause Hysteresis

This block is the back end of a receive DMA path. Frames arrive one byte per cycle on a valid/ready stream with an end-of-frame marker. Each frame is stored in the buffer that belongs to the next slot of a 256-slot descriptor ring. Every slot owns a 2048-byte buffer, so the byte address is the slot number followed by an 11-bit offset. After the last byte, the block writes a status word for that slot and advances a 16-bit producer index. Software hands buffers back by moving a 16-bit consumer index. The difference between the two indices is the number of slots that hold unread frames.

When the alignment input is set, the block writes two zero bytes at the start of the buffer before the frame data, so the header that follows lands on a 4-byte boundary. The recorded length counts these two bytes. Stored bytes are limited to a maximum length. Bytes past that limit are consumed but not written, and the descriptor is marked with an error bit. A frame that starts while every slot is occupied is consumed, discarded and counted. A pause request output follows the number of free slots with hysteresis. Its two thresholds come from a packed configuration word.

The controller has six states. `S_IDLE` waits for a frame. `S_PAD0` and `S_PAD1` write the two zero bytes. `S_DATA` stores the payload. `S_DONE` writes the descriptor and advances the producer index. `S_DROP` swallows a frame that found the ring full.

The transitions are:
- `S_IDLE` to `S_PAD0` when a byte is offered, a slot is free and alignment is on.
- `S_IDLE` to `S_DATA`, or straight to `S_DONE` for a one-byte frame, when alignment is off.
- `S_IDLE` to `S_DROP` when the ring is full, or staying in `S_IDLE` if the dropped byte is also the last one.
- `S_PAD0` to `S_PAD1` to `S_DATA`.
- `S_DATA` to `S_DONE` on the last byte.
- `S_DONE` to `S_IDLE`.
- `S_DROP` to `S_IDLE` on the last byte.

Top module: `rx_ring_writer`

## Requirements
- R1: After reset the producer index, the drop count and the pause request are 0, no buffer or descriptor write is issued, and `in_ready` is 1 while idle with alignment off.
- R2: The bytes of a stored frame are written, in order and once each, to byte address slot*2048 + offset. The slot is the producer index modulo 256, and the offset starts at 0, or at 2 with alignment on.
- R3: With alignment on, a frame's first byte is held for three cycles (idle, pad 0, pad 1) with `in_ready` low. Zero bytes are written at offsets 0 and 1, and the recorded length is the payload length plus 2.
- R4: One cycle after the last byte is accepted, exactly one descriptor write is issued at index slot. The status word carries the recorded length in bits 27:16, ones in bits 14 and 13, the error flag in bit 0, and zeros elsewhere.
- R5: The producer index grows by exactly 1 per stored frame and by 0 per dropped frame.
- R6: If producer minus consumer (mod 2^16) equals 256 when a frame starts, all of its bytes are accepted, no buffer or descriptor write occurs, the producer index is unchanged and the drop count grows by 1.
- R7: The free count is 256 minus the occupancy. The pause request is set when free ≤ low, cleared when free ≥ high, and otherwise holds. Low is taken from `thresh_cfg[31:16]` and high from `thresh_cfg[15:0]`. The output follows one cycle after the occupancy changes.
- R8: The recorded length (pad included) is capped at 1536. Bytes beyond the cap are accepted but not written, and then bit 0 of the status word is 1. A frame that exactly reaches the cap has bit 0 equal to 0.
- R9: `in_ready` is 0 in the cycle in which the descriptor is written.
- R10: A consumer-index advance in the same cycle as the first byte of a frame that meets a full ring frees a slot for that frame. The frame is stored, not dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| align_en | input | 1 | Insert two zero bytes before frame data (sampled at frame start) |
| thresh_cfg | input | 32 | Pause thresholds: low in 31:16, high in 15:0 |
| cons_idx | input | 16 | Consumer index maintained by software |
| in_valid | input | 1 | Frame byte is valid |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Byte is the last of its frame |
| in_ready | output | 1 | Byte is accepted this cycle |
| wr_en | output | 1 | Buffer byte write strobe |
| wr_addr | output | 19 | Buffer byte address {slot, offset} |
| wr_data | output | 8 | Buffer byte data |
| desc_we | output | 1 | Descriptor status write strobe |
| desc_idx | output | 8 | Descriptor slot being written |
| desc_word | output | 32 | Descriptor status word |
| prod_idx | output | 16 | Producer index |
| drop_count | output | 16 | Frames dropped for lack of a free slot |
| xoff | output | 1 | Pause request |

## Verification
The case that needs care is the ring-full decision taken in `S_IDLE` in the same cycle that software moves the consumer index. The full test is combinational on the current consumer index, so a slot freed in that cycle must be usable at once. The bench fills the ring to 256 occupied slots, then raises the consumer index by one at the same clock edge on which it presents a frame's first byte. It passes only if that frame is stored in the expected slot with an unchanged drop count, and a following frame is then dropped. The same phases also cover the interaction between producer steps and consumer releases for the pause request's hysteresis band.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PAD0,
        S_PAD1,
        S_DATA,
        S_DONE,
        S_DROP
    } rx_state_t;

    // descriptor status word layout
    localparam int LEN_LSB = 16;
    localparam int LEN_W   = 12;
    localparam int EOP_BIT = 14;
    localparam int SOP_BIT = 13;
    localparam int ERR_BIT = 0;

    // threshold configuration word layout
    localparam int THR_LO_LSB = 16;
    localparam int THR_HI_LSB = 0;
    localparam int THR_W      = 16;

    localparam int PAD_BYTES = 2;

endpackage

// File: rtl/rxr_flow.sv
module rxr_flow
    import rxr_pkg::*;
#(
    parameter int IDX_W = 16,
    parameter int RING  = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] prod,
    input  logic [IDX_W-1:0] cons,
    input  logic [31:0]      thresh_cfg,
    output logic             full,
    output logic             xoff
);
    localparam int FREE_W = IDX_W + 1;

    logic [IDX_W-1:0]  occ;
    logic [FREE_W-1:0] free_n;
    logic [FREE_W-1:0] lo_thr;
    logic [FREE_W-1:0] hi_thr;

    assign occ    = prod - cons;
    assign full   = ({1'b0, occ} >= FREE_W'(RING));
    assign free_n = full ? '0 : (FREE_W'(RING) - {1'b0, occ});
    assign lo_thr = FREE_W'(thresh_cfg[THR_LO_LSB +: THR_W]);
    assign hi_thr = FREE_W'(thresh_cfg[THR_HI_LSB +: THR_W]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            xoff <= 1'b0;
        end else if (free_n <= lo_thr) begin
            xoff <= 1'b1;
        end else if (free_n >= hi_thr) begin
            xoff <= 1'b0;
        end
    end

endmodule

// File: rtl/rxr_frame_fsm.sv
module rxr_frame_fsm
    import rxr_pkg::*;
#(
    parameter int IDX_W     = 16,
    parameter int RING      = 256,
    parameter int BUF_BYTES = 2048,
    parameter int MAX_LEN   = 1536,
    parameter int CNT_W     = 16,
    localparam int SLOT_W   = $clog2(RING),
    localparam int OFF_W    = $clog2(BUF_BYTES),
    localparam int ADDR_W   = SLOT_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              align_en,
    input  logic              full,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    input  logic              in_last,
    output logic              in_ready,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              desc_we,
    output logic [SLOT_W-1:0] desc_idx,
    output logic [31:0]       desc_word,
    output logic [IDX_W-1:0]  prod_idx,
    output logic [CNT_W-1:0]  drop_count,
    output rx_state_t         state_o
);
    rx_state_t         state_q, state_d;
    logic [LEN_W-1:0]  offset_q;
    logic              trunc_q;
    logic [IDX_W-1:0]  prod_q;
    logic [CNT_W-1:0]  drop_q;
    logic [OFF_W-1:0]  wr_off;
    logic [SLOT_W-1:0] slot;
    logic              has_room;
    logic              start_ok;

    assign slot     = prod_q[SLOT_W-1:0];
    assign has_room = (offset_q < LEN_W'(MAX_LEN));
    assign start_ok = in_valid && !full;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (in_valid && full)       state_d = in_last ? S_IDLE : S_DROP;
                else if (start_ok)          state_d = align_en ? S_PAD0
                                                    : (in_last ? S_DONE : S_DATA);
            end
            S_PAD0: state_d = S_PAD1;
            S_PAD1: state_d = S_DATA;
            S_DATA: if (in_valid && in_last) state_d = S_DONE;
            S_DONE: state_d = S_IDLE;
            S_DROP: if (in_valid && in_last) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        in_ready = 1'b0;
        wr_en    = 1'b0;
        wr_off   = '0;
        wr_data  = 8'h00;
        desc_we  = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                in_ready = full || !align_en;
                wr_en    = start_ok && !align_en;
                wr_data  = in_data;
            end
            S_PAD0: wr_en = 1'b1;
            S_PAD1: begin
                wr_en  = 1'b1;
                wr_off = OFF_W'(1);
            end
            S_DATA: begin
                in_ready = 1'b1;
                wr_en    = in_valid && has_room;
                wr_off   = offset_q[OFF_W-1:0];
                wr_data  = in_data;
            end
            S_DONE: desc_we = 1'b1;
            S_DROP: in_ready = 1'b1;
            default: ;
        endcase
    end

    always_comb begin
        desc_word                     = '0;
        desc_word[LEN_LSB +: LEN_W]   = offset_q;
        desc_word[EOP_BIT]            = 1'b1;
        desc_word[SOP_BIT]            = 1'b1;
        desc_word[ERR_BIT]            = trunc_q;
    end

    // frame datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            offset_q <= '0;
            trunc_q  <= 1'b0;
            prod_q   <= '0;
            drop_q   <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    trunc_q  <= 1'b0;
                    offset_q <= (start_ok && !align_en) ? LEN_W'(1) : '0;
                    if (in_valid && full) drop_q <= drop_q + 1'b1;
                end
                S_PAD1: offset_q <= LEN_W'(PAD_BYTES);
                S_DATA: begin
                    if (in_valid) begin
                        if (has_room) offset_q <= offset_q + 1'b1;
                        else          trunc_q  <= 1'b1;
                    end
                end
                S_DONE: prod_q <= prod_q + 1'b1;
                default: ;
            endcase
        end
    end

    assign wr_addr    = {slot, wr_off};
    assign desc_idx   = slot;
    assign prod_idx   = prod_q;
    assign drop_count = drop_q;
    assign state_o    = state_q;

endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
    import rxr_pkg::*;
#(
    parameter int IDX_W     = 16,
    parameter int RING      = 256,
    parameter int BUF_BYTES = 2048,
    parameter int MAX_LEN   = 1536,
    parameter int CNT_W     = 16,
    localparam int SLOT_W   = $clog2(RING),
    localparam int ADDR_W   = SLOT_W + $clog2(BUF_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              align_en,
    input  logic [31:0]       thresh_cfg,
    input  logic [IDX_W-1:0]  cons_idx,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    input  logic              in_last,
    output logic              in_ready,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              desc_we,
    output logic [SLOT_W-1:0] desc_idx,
    output logic [31:0]       desc_word,
    output logic [IDX_W-1:0]  prod_idx,
    output logic [CNT_W-1:0]  drop_count,
    output logic              xoff
);
    logic      ring_full;
    rx_state_t fsm_state;

    rxr_flow #(
        .IDX_W (IDX_W),
        .RING  (RING)
    ) u_flow (
        .clk        (clk),
        .rst_n      (rst_n),
        .prod       (prod_idx),
        .cons       (cons_idx),
        .thresh_cfg (thresh_cfg),
        .full       (ring_full),
        .xoff       (xoff)
    );

    rxr_frame_fsm #(
        .IDX_W     (IDX_W),
        .RING      (RING),
        .BUF_BYTES (BUF_BYTES),
        .MAX_LEN   (MAX_LEN),
        .CNT_W     (CNT_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .align_en   (align_en),
        .full       (ring_full),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .in_last    (in_last),
        .in_ready   (in_ready),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .desc_we    (desc_we),
        .desc_idx   (desc_idx),
        .desc_word  (desc_word),
        .prod_idx   (prod_idx),
        .drop_count (drop_count),
        .state_o    (fsm_state)
    );

endmodule

// File: rtl/rx_ring_writer_chk.sv
module rx_ring_writer_chk
    import rxr_pkg::*;
#(
    parameter int IDX_W   = 16,
    parameter int CNT_W   = 16,
    parameter int OFF_W   = 11,
    parameter int ADDR_W  = 19,
    parameter int MAX_LEN = 1536
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_last,
    input logic              in_ready,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [7:0]        wr_data,
    input logic              desc_we,
    input logic [IDX_W-1:0]  prod_idx,
    input logic [CNT_W-1:0]  drop_count,
    input logic              xoff,
    input logic              ring_full,
    input rx_state_t         fsm_state
);

    assert_prod_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (prod_idx != $past(prod_idx)) |-> (prod_idx == $past(prod_idx) + 1'b1));

    assert_desc_after_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
        desc_we |-> $past(in_valid && in_last && in_ready));

    assert_no_desc_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        desc_we |-> !in_ready);

    assert_full_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == S_IDLE && ring_full) |-> !wr_en);

    assert_drop_when_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_count != $past(drop_count)) |-> $past(ring_full));

    assert_full_pause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ring_full |=> xoff);

    assert_pad_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == S_PAD0 || fsm_state == S_PAD1) |-> (!in_ready && wr_en && wr_data == 8'h00));

    assert_write_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_addr[OFF_W-1:0]) < MAX_LEN));

endmodule

bind rx_ring_writer rx_ring_writer_chk #(
    .IDX_W   (IDX_W),
    .CNT_W   (CNT_W),
    .OFF_W   ($clog2(BUF_BYTES)),
    .ADDR_W  (ADDR_W),
    .MAX_LEN (MAX_LEN)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_last    (in_last),
    .in_ready   (in_ready),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .desc_we    (desc_we),
    .prod_idx   (prod_idx),
    .drop_count (drop_count),
    .xoff       (xoff),
    .ring_full  (ring_full),
    .fsm_state  (fsm_state)
);

// File: tb/rx_ring_writer_test.sv
`timescale 1ns/100ps
module rx_ring_writer_test;

    localparam int MAXL = 1536;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        align_en = 1'b0;
    logic [31:0] thresh_cfg = {16'd5, 16'd16};
    logic [15:0] cons_idx = 16'd0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        in_last = 1'b0;
    logic        in_ready, wr_en, desc_we, xoff;
    logic [18:0] wr_addr;
    logic [7:0]  wr_data, desc_idx;
    logic [31:0] desc_word;
    logic [15:0] prod_idx, drop_count;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0]  shadow [int];
    logic [31:0] desc_sh [0:255];
    int          wr_cnt = 0;
    int          desc_cnt = 0;
    logic [7:0]  byte_q [0:2047];

    always #2.5 clk = ~clk;

    rx_ring_writer uut (
        .clk(clk), .rst_n(rst_n), .align_en(align_en), .thresh_cfg(thresh_cfg),
        .cons_idx(cons_idx), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
        .in_ready(in_ready), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .desc_we(desc_we), .desc_idx(desc_idx), .desc_word(desc_word),
        .prod_idx(prod_idx), .drop_count(drop_count), .xoff(xoff)
    );

    // monitor: sample 1 ns before each rising edge
    always @(negedge clk) begin
        #1.5;
        if (rst_n) begin
            if (wr_en) begin
                shadow[int'(wr_addr)] = wr_data;
                wr_cnt++;
            end
            if (desc_we) begin
                desc_sh[desc_idx] = desc_word;
                desc_cnt++;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_word(input int rec_len, input bit err);
        logic [31:0] w;
        w = 32'h0000_6000;
        w[27:16] = 12'(rec_len);
        w[0] = err;
        return w;
    endfunction

    task automatic run_frame(input int len, input bit al, input bit exp_drop, input int bump);
        int pad, rec, exp_len, stalls, mism, d0, w0;
        bit err;
        logic [15:0] p0, dr0;
        logic [7:0]  slot;
        logic [7:0]  eb;
        pad = al ? 2 : 0;
        rec = len + pad;
        exp_len = (rec > MAXL) ? MAXL : rec;
        err = (rec > MAXL);
        stalls = 0;
        @(negedge clk);
        p0 = prod_idx; dr0 = drop_count; d0 = desc_cnt; w0 = wr_cnt;
        slot = p0[7:0];
        align_en = al;
        for (int k = 0; k < 2048; k++)
            if (shadow.exists(int'(slot) * 2048 + k)) shadow.delete(int'(slot) * 2048 + k);
        desc_sh[slot] = 32'hDEAD_BEEF;
        for (int i = 0; i < len; i++) byte_q[i] = 8'($urandom);
        for (int i = 0; i < len; i++) begin
            if (i > 0) @(negedge clk);
            in_valid = 1'b1; in_data = byte_q[i]; in_last = (i == len - 1);
            if (i == 0) cons_idx = cons_idx + 16'(bump);
            #1.5;
            while (!in_ready) begin
                if (i == 0) stalls++;
                @(negedge clk); #1.5;
            end
        end
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
        #1.5;
        if (!exp_drop) check(in_ready == 1'b0, "R9", "ready in descriptor cycle", in_ready, 0);
        repeat (2) @(negedge clk);
        if (exp_drop) begin
            check(desc_cnt == d0, "R6", "descriptor writes on drop", desc_cnt - d0, 0);
            check(wr_cnt == w0, "R6", "buffer writes on drop", wr_cnt - w0, 0);
            check(prod_idx == p0, "R5", "producer on drop", prod_idx, p0);
            check(drop_count == dr0 + 16'd1, "R6", "drop count", drop_count, dr0 + 16'd1);
        end else begin
            check(stalls == (al ? 3 : 0), "R3", "first byte stall cycles", stalls, al ? 3 : 0);
            check(desc_cnt == d0 + 1, "R4", "descriptor write count", desc_cnt - d0, 1);
            check(desc_sh[slot] == exp_word(exp_len, err), err ? "R8" : "R4", "status word",
                  desc_sh[slot], exp_word(exp_len, err));
            check(wr_cnt - w0 == exp_len, err ? "R8" : "R2", "byte writes", wr_cnt - w0, exp_len);
            mism = 0;
            for (int k = 0; k < exp_len; k++) begin
                eb = (k < pad) ? 8'h00 : byte_q[k - pad];
                if (!shadow.exists(int'(slot) * 2048 + k)) mism++;
                else if (shadow[int'(slot) * 2048 + k] !== eb) mism++;
            end
            check(mism == 0, al ? "R3" : "R2", "buffer content mismatches", mism, 0);
            check(prod_idx == p0 + 16'd1, "R5", "producer step", prod_idx, p0 + 16'd1);
            check(drop_count == dr0, "R6", "drop count unchanged", drop_count, dr0);
        end
    endtask

    task automatic set_cons(input logic [15:0] v);
        @(negedge clk);
        cons_idx = v;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1.5;
        // R1 reset state
        check(prod_idx == 0, "R1", "producer after reset", prod_idx, 0);
        check(drop_count == 0, "R1", "drop count after reset", drop_count, 0);
        check(xoff == 0, "R1", "pause after reset", xoff, 0);
        check(!wr_en && !desc_we, "R1", "writes after reset", {wr_en, desc_we}, 0);
        check(in_ready == 1, "R1", "ready while idle", in_ready, 1);

        // directed frames (R2, R3, R4)
        run_frame(1, 1'b0, 1'b0, 0);
        run_frame(1, 1'b1, 1'b0, 0);
        run_frame(60, 1'b1, 1'b0, 0);
        run_frame(17, 1'b0, 1'b0, 0);

        // constrained random frames, ring kept drained
        for (int n = 0; n < 40; n++) begin
            run_frame($urandom_range(1, 64), 1'($urandom_range(0, 1)), 1'b0, 0);
            set_cons(prod_idx);
        end

        // R8 length cap boundaries
        run_frame(1534, 1'b1, 1'b0, 0);
        run_frame(1535, 1'b1, 1'b0, 0);
        run_frame(1536, 1'b0, 1'b0, 0);
        run_frame(1600, 1'b0, 1'b0, 0);
        set_cons(prod_idx);

        // fill the ring, watching the pause threshold (R7)
        for (int n = 1; n <= 256; n++) begin
            run_frame(1, 1'b0, 1'b0, 0);
            if (n == 250) check(xoff == 0, "R7", "pause at free 6", xoff, 0);
            if (n == 251) check(xoff == 1, "R7", "pause at free 5", xoff, 1);
        end
        // full: drop (R6)
        run_frame(3, 1'b1, 1'b1, 0);
        check(xoff == 1, "R7", "pause while full", xoff, 1);

        // hysteresis band (R7)
        set_cons(cons_idx + 16'd11);
        check(xoff == 1, "R7", "pause held at free 11", xoff, 1);
        set_cons(cons_idx + 16'd5);
        check(xoff == 0, "R7", "pause released at free 16", xoff, 0);
        thresh_cfg = {16'd20, 16'd40};
        repeat (2) @(negedge clk);
        check(xoff == 1, "R7", "low threshold from bits 31:16", xoff, 1);
        thresh_cfg = {16'd5, 16'd16};
        repeat (2) @(negedge clk);
        check(xoff == 0, "R7", "high threshold from bits 15:0", xoff, 0);

        // refill, then release a slot in the frame's first cycle (R10)
        for (int n = 0; n < 16; n++) run_frame(2, 1'b0, 1'b0, 0);
        run_frame(5, 1'b0, 1'b0, 1);
        check(drop_count == 16'd1, "R10", "same-cycle release not dropped", drop_count, 1);
        run_frame(4, 1'b0, 1'b1, 0);
        run_frame(5, 1'b1, 1'b0, 1);
        check(drop_count == 16'd2, "R10", "aligned same-cycle release", drop_count, 2);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule